// File: doc/BRIEF.md
# Chronological Alarm Number Table

This block keeps a list of the alarm numbers that are currently active, ordered by when each was raised. The oldest entry sits in slot 0 and newer ones follow in arrival order, with at most `SLOTS` entries (16 by default). A single command port, made of a valid strobe, a two-bit opcode and a number, drives the table. A set command appends a number at the tail. A clear command removes a named number from anywhere in the list and pulls the later entries up to close the gap. A shift command drops the head, which acknowledges the oldest alarm.

Every slot is presented in parallel on one flat bus, along with the live entry count and the head entry, which is the first-detected alarm. The value 0 is reserved to mean "no alarm", so empty slots read 0. Each command is applied at one rising clock edge, and the whole table is consistent again in the cycle that follows. This means a new command can be accepted on every cycle.

Top module: `alarm_log_table`

## Requirements
- R1: When `rst` is high at a rising edge, all slots, `entryCount`, `firstNum` and `overflowPulse` become 0.
- R2: A set command (opcode 2'b01) with a nonzero number that is not already present and a count below `SLOTS` writes the number into slot `entryCount` and raises the count by 1.
- R3: A clear command (opcode 2'b10) whose number is stored at slot k removes that entry. Each entry in slots k+1 and above moves up one slot, the slot that becomes free reads 0, and the count falls by 1.
- R4: A shift command (opcode 2'b11) on a non-empty table discards slot 0, moves every other entry up one slot and lowers the count by 1.
- R5: A set of a new nonzero number while the count equals `SLOTS` leaves the table and the count unchanged, and it drives `overflowPulse` high for exactly the one cycle after that edge.
- R6: `firstNum` always equals slot 0. It is 0 when the table is empty and takes the next entry's value after a shift or after a clear of the head.
- R7: Every slot at an index equal to or above `entryCount` reads 0.
- R8: A set whose number is 0, or whose number is already stored, changes nothing and does not pulse `overflowPulse`.
- R9: A clear of 0 or of a number that is not stored, and a shift on an empty table, leave the table and the count unchanged.
- R10: With `cmdValid` low, or with opcode 2'b00, nothing changes. `entryCount` stays within 0 to `SLOTS`.
- R11: A command presented before a rising edge is fully visible on every output after that edge. Slot i is carried on `slotsFlat[i*NUM_W +: NUM_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command strobe for this cycle |
| cmdOp | input | 2 | 00 none, 01 set, 10 clear, 11 shift |
| cmdNum | input | NUM_W | Alarm number for set and clear |
| slotsFlat | output | SLOTS*NUM_W | All slots, slot 0 in the low bits |
| entryCount | output | $clog2(SLOTS+1) | Number of stored entries |
| firstNum | output | NUM_W | Head entry (oldest alarm), 0 if empty |
| overflowPulse | output | 1 | One-cycle flag for a set rejected because the table was full |

## Verification
The bench builds the block with its default values, `SLOTS` = 16 and `NUM_W` = 16. Random alarm numbers come from the small range 0 to 24. With that range, duplicate sets, sets of the reserved 0, clears that find no match and a full table all occur often under random traffic. A wide alarm number alone would not give that. Sixteen slots against 24 candidate numbers keep both the full and the empty boundary within reach, so compaction is exercised at every slot position, including the last one.

// File: rtl/alarm_tbl_pkg.sv
package alarm_tbl_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_SET   = 2'b01,
    OP_CLR   = 2'b10,
    OP_SHIFT = 2'b11
  } alarm_op_e;

  // Strobes from control to the storage datapath; at most one is high per cycle.
  typedef struct packed {
    logic doAppend;
    logic doRemove;
    logic doShift;
    logic rejectFull;
  } tbl_strobe_t;

endpackage

// File: rtl/alarm_tbl_ctrl.sv
module alarm_tbl_ctrl
  import alarm_tbl_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int NUM_W = 16,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmdValid,
  input  logic [1:0]                 cmdOp,
  input  logic [NUM_W-1:0]           cmdNum,
  input  logic [SLOTS-1:0][NUM_W-1:0] slotsIn,
  input  logic [CNT_W-1:0]           entryCount,
  output tbl_strobe_t                strb,
  output logic [IDX_W-1:0]           removeIdx
);

  logic [SLOTS-1:0] hitVec;
  logic             found;
  logic             isFull;
  logic             isEmpty;
  logic             numZero;

  assign numZero = (cmdNum == '0);
  assign isFull  = (entryCount == CNT_W'(SLOTS));
  assign isEmpty = (entryCount == '0);

  // One comparator per slot, qualified by occupancy.
  for (genvar i = 0; i < SLOTS; i++) begin : g_match
    assign hitVec[i] = (CNT_W'(i) < entryCount) && (slotsIn[i] == cmdNum) && !numZero;
  end

  assign found = |hitVec;

  // Lowest matching slot wins (numbers are unique, so at most one hits).
  always_comb begin
    removeIdx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hitVec[i]) removeIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      case (alarm_op_e'(cmdOp))
        OP_SET: begin
          if (!numZero && !found) begin
            if (isFull) strb.rejectFull = 1'b1;
            else        strb.doAppend   = 1'b1;
          end
        end
        OP_CLR:   strb.doRemove = found;
        OP_SHIFT: strb.doShift  = !isEmpty;
        default:  strb = '0;
      endcase
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.doAppend, strb.doRemove, strb.doShift, strb.rejectFull}));

  // R8
  no_dup_match_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(hitVec) <= 1);

endmodule

// File: rtl/alarm_tbl_store.sv
module alarm_tbl_store
  import alarm_tbl_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int NUM_W = 16,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  tbl_strobe_t                 strb,
  input  logic [IDX_W-1:0]            removeIdx,
  input  logic [NUM_W-1:0]            appendNum,
  output logic [SLOTS-1:0][NUM_W-1:0] slotsQ,
  output logic [CNT_W-1:0]            countQ,
  output logic                        overflowQ
);

  logic [SLOTS-1:0][NUM_W-1:0] slotsNxt;
  logic [IDX_W-1:0]            dropIdx;
  logic                        doDrop;

  // A shift is a removal at slot 0; both use the same parallel compaction.
  assign doDrop  = strb.doShift || strb.doRemove;
  assign dropIdx = strb.doShift ? '0 : removeIdx;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [NUM_W-1:0] upper;
    if (i == SLOTS - 1) begin : g_last
      assign upper = '0;
    end else begin : g_mid
      assign upper = slotsQ[i+1];
    end

    always_comb begin
      slotsNxt[i] = slotsQ[i];
      if (doDrop && (IDX_W'(i) >= dropIdx)) slotsNxt[i] = upper;
      if (strb.doAppend && (countQ == CNT_W'(i))) slotsNxt[i] = appendNum;
    end

    // R7
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (CNT_W'(i) >= countQ) |-> (slotsQ[i] == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slotsQ    <= '0;
      countQ    <= '0;
      overflowQ <= 1'b0;
    end else begin
      slotsQ    <= slotsNxt;
      overflowQ <= strb.rejectFull;
      if (strb.doAppend)  countQ <= countQ + 1'b1;
      else if (doDrop)    countQ <= countQ - 1'b1;
    end
  end

  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    countQ <= CNT_W'(SLOTS));

  // R2
  append_count_chk: assert property (@(posedge clk) disable iff (rst)
    strb.doAppend |=> (countQ == $past(countQ) + 1'b1));

  // R3
  remove_count_chk: assert property (@(posedge clk) disable iff (rst)
    doDrop |=> (countQ == $past(countQ) - 1'b1));

  // R5
  overflow_full_chk: assert property (@(posedge clk) disable iff (rst)
    strb.rejectFull |=> (overflowQ && $stable(countQ) && $stable(slotsQ)));

endmodule

// File: rtl/alarm_log_table.sv
module alarm_log_table
  import alarm_tbl_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int NUM_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmdValid,
  input  logic [1:0]                 cmdOp,
  input  logic [NUM_W-1:0]           cmdNum,
  output logic [SLOTS*NUM_W-1:0]     slotsFlat,
  output logic [$clog2(SLOTS+1)-1:0] entryCount,
  output logic [NUM_W-1:0]           firstNum,
  output logic                       overflowPulse
);

  localparam int IDX_W = $clog2(SLOTS);

  tbl_strobe_t                 strb;
  logic [IDX_W-1:0]            removeIdx;
  logic [SLOTS-1:0][NUM_W-1:0] slotsQ;

  alarm_tbl_ctrl #(.SLOTS(SLOTS), .NUM_W(NUM_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdNum     (cmdNum),
    .slotsIn    (slotsQ),
    .entryCount (entryCount),
    .strb       (strb),
    .removeIdx  (removeIdx)
  );

  alarm_tbl_store #(.SLOTS(SLOTS), .NUM_W(NUM_W)) store_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .removeIdx (removeIdx),
    .appendNum (cmdNum),
    .slotsQ    (slotsQ),
    .countQ    (entryCount),
    .overflowQ (overflowPulse)
  );

  assign slotsFlat = slotsQ;
  assign firstNum  = slotsQ[0];

  // R6
  head_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (entryCount == '0) |-> (firstNum == '0));

  // R5
  overflow_single_chk: assert property (@(posedge clk) disable iff (rst)
    overflowPulse |-> ($past(entryCount) == ($clog2(SLOTS+1))'(SLOTS)));

endmodule

// File: tb/alarm_log_table_tb_top.sv
module alarm_log_table_tb_top;

  localparam int SLOTS      = 16;
  localparam int NUM_W      = 16;
  localparam int CNT_W      = $clog2(SLOTS + 1);
  localparam int CLK_PERIOD = 10;

  logic                   clk = 1'b0;
  logic                   rst;
  logic                   cmdValid;
  logic [1:0]             cmdOp;
  logic [NUM_W-1:0]       cmdNum;
  logic [SLOTS*NUM_W-1:0] slotsFlat;
  logic [CNT_W-1:0]       entryCount;
  logic [NUM_W-1:0]       firstNum;
  logic                   overflowPulse;

  int checks = 0;
  int errors = 0;

  logic [NUM_W-1:0] mSlot [SLOTS];
  int               mCount;
  bit               mOvf;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_log_table #(.SLOTS(SLOTS), .NUM_W(NUM_W)) dut_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdNum(cmdNum),
    .slotsFlat(slotsFlat), .entryCount(entryCount), .firstNum(firstNum),
    .overflowPulse(overflowPulse)
  );

  function automatic int findSlot(logic [NUM_W-1:0] num);
    for (int i = 0; i < mCount; i++) if (mSlot[i] == num && num != 0) return i;
    return -1;
  endfunction

  task automatic modelDrop(int k);
    for (int i = k; i < SLOTS - 1; i++) mSlot[i] = mSlot[i+1];
    mSlot[SLOTS-1] = '0;
    mCount--;
  endtask

  task automatic modelApply(bit v, logic [1:0] op, logic [NUM_W-1:0] num);
    int k;
    mOvf = 0;
    if (!v) return;
    case (op)
      2'b01: if (num != 0 && findSlot(num) < 0) begin
               if (mCount == SLOTS) mOvf = 1;
               else begin mSlot[mCount] = num; mCount++; end
             end
      2'b10: begin k = findSlot(num); if (k >= 0) modelDrop(k); end
      2'b11: if (mCount > 0) modelDrop(0);
      default: ;
    endcase
  endtask

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check(req, "count", entryCount, mCount);
    check(req, "first", firstNum, mSlot[0]);
    check(req, "overflow", overflowPulse, mOvf);
    for (int i = 0; i < SLOTS; i++)
      check(req, $sformatf("slot%0d", i), slotsFlat[i*NUM_W +: NUM_W], mSlot[i]);
  endtask

  // Drive at a falling edge, let one rising edge apply it (R11), sample at the next falling edge.
  task automatic issue(string req, bit v, logic [1:0] op, logic [NUM_W-1:0] num);
    cmdValid = v; cmdOp = op; cmdNum = num;
    @(negedge clk);
    modelApply(v, op, num);
    checkAll(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; cmdValid = 1'b0; cmdOp = 2'b00; cmdNum = '0;
    for (int i = 0; i < SLOTS; i++) mSlot[i] = '0;
    mCount = 0; mOvf = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    checkAll("R1");

    // Append, mid-table clear with compaction, append into freed tail
    issue("R2", 1, 2'b01, 16'd50);
    issue("R2", 1, 2'b01, 16'd25);
    issue("R2", 1, 2'b01, 16'd99);
    issue("R3", 1, 2'b10, 16'd25);
    issue("R7", 1, 2'b01, 16'd15);
    issue("R2", 1, 2'b01, 16'd70);
    issue("R2", 1, 2'b01, 16'd65);
    issue("R4", 1, 2'b11, 16'd0);
    check("R6", "head after shift", firstNum, 16'd99);
    issue("R6", 1, 2'b10, 16'd99);
    issue("R8", 1, 2'b01, 16'd70);
    issue("R8", 1, 2'b01, 16'd0);
    issue("R9", 1, 2'b10, 16'd1234);
    issue("R9", 1, 2'b10, 16'd0);
    issue("R10", 0, 2'b01, 16'd77);
    issue("R10", 1, 2'b00, 16'd77);
    // Empty the table, then shift on empty
    while (mCount > 0) issue("R4", 1, 2'b11, 16'd0);
    issue("R9", 1, 2'b11, 16'd0);
    check("R6", "head empty", firstNum, 0);
    // Fill to capacity, then overflow
    for (int i = 1; i <= SLOTS; i++) issue("R2", 1, 2'b01, NUM_W'(100 + i));
    issue("R5", 1, 2'b01, 16'd500);
    check("R5", "overflow pulse", overflowPulse, 1);
    issue("R5", 1, 2'b00, 16'd0);
    check("R5", "overflow one cycle", overflowPulse, 0);
    issue("R8", 1, 2'b01, 16'd105);
    issue("R3", 1, 2'b10, NUM_W'(100 + SLOTS));
    issue("R3", 1, 2'b10, 16'd101);
    // Random traffic over a small number range
    for (int n = 0; n < 4000; n++) begin
      bit v = ($urandom_range(0, 9) != 0);
      logic [1:0] op = 2'($urandom_range(0, 3));
      if (op == 2'b01 && $urandom_range(0, 2) == 0) op = 2'b01;
      issue("R11", v, op, NUM_W'($urandom_range(0, 24)));
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < SLOTS; i++) mSlot[i] = '0;
    mCount = 0; mOvf = 0;
    checkAll("R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule